// File: doc/BRIEF.md
# Address Sweep Chip-Select Mapper

This block takes the place of a processor on a board under test so that the board's address decoding can be charted from outside. A `start` pulse begins a sweep. The block drives the target address to zero and holds the target's reset low for a programmable number of cycles, then releases it. It then walks the address from zero up to all ones. The low address field counts fastest and carries into the high field. While it walks, the read/write line stays at read and a phase-2 style clock is driven.

At each address the block waits a programmable settle time. It then samples twelve active-low chip-select lines from the target. These lines arrive as a group of eight and a group of four and are resynchronised before use. A record is produced only when the sampled pattern differs from the one taken at the previous address. The first address of a sweep always produces a record. The result is a compressed memory map: each record gives the address where a new decode region begins, together with the pattern seen there.

Records leave on a valid/ready stream. While `rec_valid` is high and `rec_ready` is low, the record fields hold their values and the sweep halts with the address frozen, so back-pressure never drops a transition. A record transfers on a clock edge where both signals are high. `done` rises once the final address has been sampled and any record it produced has been taken. `done` stays high until the next `start`.

Top module: `sweep_logger`

## Requirements
- R1: After `rst_n` is released, and before any `start`: `tgt_reset_n`=1, `tgt_addr`=0, `tgt_phi2`=0, `rec_valid`=0, `done`=0.
- R2: A `start` pulse in idle or done drives `tgt_reset_n` low for exactly `rst_cycles`+1 cycles, with `tgt_addr` at 0 throughout. After that the sweep begins at address 0.
- R3: Each sweep presents every address exactly once, in ascending order from 0 to all ones. The low `LO_W` bits form the inner count and carry into the high `HI_W` bits.
- R4: For each address, `tgt_phi2` is high for `settle_cycles`+1 consecutive cycles, and `tgt_reset_n` is high whenever `tgt_phi2` is high. `tgt_addr` changes only on an edge that follows a cycle with `tgt_phi2` low. The selects pass through `SYNC_STAGES` flops and are sampled on the last high-phase cycle.
- R5: The sampled vector has `sel_grp_a_n` in bits 7:0 and `sel_grp_b_n` in bits 11:8, both active low. A record, holding the address and this vector, is produced only when the vector differs from the one sampled at the previous address.
- R6: The first address of every sweep, including a sweep restarted from done, always produces a record.
- R7: While `rec_valid`=1 and `rec_ready`=0, on the next cycle `rec_valid` stays 1, `rec_addr` and `rec_sel` are unchanged, and `tgt_addr` does not move. No record is lost.
- R8: `tgt_rw` is 1 (read) at all times.
- R9: `done` rises only after the last address has been sampled and its record, if any, has been accepted. While `done` is high, `rec_valid`=0 and `tgt_phi2`=0. `done` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (accepted in idle or done) |
| rst_cycles | input | RST_W | Target reset hold length minus one |
| settle_cycles | input | SET_W | Settle time per address minus one |
| sel_grp_a_n | input | GA_W | Active-low selects, group A |
| sel_grp_b_n | input | GB_W | Active-low selects, group B |
| tgt_addr | output | HI_W+LO_W | Address driven to the target |
| tgt_rw | output | 1 | Read/write toward target, 1 = read |
| tgt_phi2 | output | 1 | Phase-2 clock toward target |
| tgt_reset_n | output | 1 | Active-low reset toward target |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record accepted by consumer |
| rec_addr | output | HI_W+LO_W | Address where the pattern changed |
| rec_sel | output | GA_W+GB_W | New select pattern |
| done | output | 1 | Sweep complete |

## Verification
The bench builds the block with a 2-bit high field and a 3-bit low field, so a full sweep is 32 addresses. This keeps the wrap from the low field into the high field, the final all-ones address and the completion handshake within a few hundred cycles. Two synchroniser stages are kept. The bench's target model adds two more cycles of decode latency, so the settle value used (6) is one the model actually needs. A stall pattern on `rec_ready` catches the address freezing and the record holding. A record placed on the final address checks that `done` waits for the last acceptance. A second sweep with `rst_cycles`=0 and a constant decode covers the shortest reset pulse and the forced first record.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RESET  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_EMIT   = 3'd3,
    ST_NEXT   = 3'd4,
    ST_DONE   = 3'd5
  } sweep_state_t;
endpackage

// File: rtl/sweep_addr_gen.sv
// Nested address counter: low field inner, high field outer.
module sweep_addr_gen #(
  parameter int HI_W = 8,
  parameter int LO_W = 8,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;

  assign lo_wrap = &lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo_q <= '0;
    end else if (step) begin
      lo_q <= lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hi_q <= '0;
    end else if (step && lo_wrap) begin
      hi_q <= hi_q + 1'b1;
    end
  end

  assign addr = {hi_q, lo_q};
  assign last = lo_wrap & (&hi_q);
endmodule

// File: rtl/sweep_sync.sv
// Resynchroniser for the asynchronous select lines; depth chosen by parameter.
module sweep_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= '1;
          else        stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sweep_delay_timer.sv
// Up counter that stops at a limit; clear restarts it from zero.
module sweep_delay_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sweep_change_det.sv
// Keeps the previous sample and flags a new pattern (or the first sample).
module sweep_change_det #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         load,
  input  logic [W-1:0] cur,
  output logic         differs
);
  logic [W-1:0] prev_q;
  logic         first_q;

  assign differs = first_q || (cur != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '1;
      first_q <= 1'b1;
    end else if (arm) begin
      first_q <= 1'b1;
    end else if (load) begin
      prev_q  <= cur;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_seq_fsm.sv
module sweep_seq_fsm
  import sweep_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         expired,
  input  logic         differs,
  input  logic         last,
  input  logic         rec_ready,
  output sweep_state_t state,
  output logic         tmr_clear,
  output logic         addr_clear,
  output logic         addr_step,
  output logic         arm,
  output logic         load
);
  sweep_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_clear  = 1'b1;
    addr_clear = 1'b0;
    addr_step  = 1'b0;
    arm        = 1'b0;
    load       = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d       = ST_RESET;
          addr_clear = 1'b1;
          arm        = 1'b1;
        end
      end
      ST_RESET: begin
        if (!expired) tmr_clear = 1'b0;
        else          st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!expired) begin
          tmr_clear = 1'b0;
        end else begin
          load = 1'b1;
          st_d = differs ? ST_EMIT : ST_NEXT;
        end
      end
      ST_EMIT: begin
        if (rec_ready) st_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (last) begin
          st_d = ST_DONE;
        end else begin
          addr_step = 1'b1;
          st_d      = ST_SETTLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/sweep_logger.sv
module sweep_logger
  import sweep_pkg::*;
#(
  parameter int HI_W        = 8,
  parameter int LO_W        = 8,
  parameter int GA_W        = 8,
  parameter int GB_W        = 4,
  parameter int RST_W       = 16,
  parameter int SET_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = HI_W + LO_W,
  localparam int SEL_W  = GA_W + GB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RST_W-1:0]  rst_cycles,
  input  logic [SET_W-1:0]  settle_cycles,
  input  logic [GA_W-1:0]   sel_grp_a_n,
  input  logic [GB_W-1:0]   sel_grp_b_n,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_rw,
  output logic              tgt_phi2,
  output logic              tgt_reset_n,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [SEL_W-1:0]  rec_sel,
  output logic              done
);
  localparam int TMR_W = (RST_W > SET_W) ? RST_W : SET_W;

  sweep_state_t      state;
  logic              tmr_clear, addr_clear, addr_step, arm, load;
  logic              expired, differs, last;
  logic [TMR_W-1:0]  limit;
  logic [SEL_W-1:0]  sel_sync;
  logic [ADDR_W-1:0] rec_addr_q;
  logic [SEL_W-1:0]  rec_sel_q;

  sweep_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .expired   (expired),
    .differs   (differs),
    .last      (last),
    .rec_ready (rec_ready),
    .state     (state),
    .tmr_clear (tmr_clear),
    .addr_clear(addr_clear),
    .addr_step (addr_step),
    .arm       (arm),
    .load      (load)
  );

  sweep_addr_gen #(.HI_W(HI_W), .LO_W(LO_W)) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(addr_clear),
    .step (addr_step),
    .addr (tgt_addr),
    .last (last)
  );

  assign limit = (state == ST_RESET) ? TMR_W'(rst_cycles) : TMR_W'(settle_cycles);

  sweep_delay_timer #(.W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_clear),
    .limit  (limit),
    .expired(expired)
  );

  sweep_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sel_grp_b_n, sel_grp_a_n}),
    .q    (sel_sync)
  );

  sweep_change_det #(.W(SEL_W)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .load   (load),
    .cur    (sel_sync),
    .differs(differs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_addr_q <= '0;
      rec_sel_q  <= '1;
    end else if (load && differs) begin
      rec_addr_q <= tgt_addr;
      rec_sel_q  <= sel_sync;
    end
  end

  assign rec_addr    = rec_addr_q;
  assign rec_sel     = rec_sel_q;
  assign rec_valid   = (state == ST_EMIT);
  assign tgt_phi2    = (state == ST_SETTLE);
  assign tgt_reset_n = (state != ST_RESET);
  assign tgt_rw      = 1'b1;
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/sweep_logger_chk.sv
module sweep_logger_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              tgt_phi2,
  input logic              tgt_reset_n,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [SEL_W-1:0]  rec_sel,
  input logic              done
);
  assert_rec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_addr) && $stable(rec_sel));

  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> $stable(tgt_addr));

  assert_addr_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgt_addr) |-> $past(!tgt_phi2));

  assert_phi2_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_phi2 |-> tgt_reset_n);

  assert_reset_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_reset_n |-> tgt_addr == '0);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid && !tgt_phi2 && tgt_reset_n);

  assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&tgt_addr));
endmodule

bind sweep_logger sweep_logger_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tgt_addr   (tgt_addr),
  .tgt_phi2   (tgt_phi2),
  .tgt_reset_n(tgt_reset_n),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_addr   (rec_addr),
  .rec_sel    (rec_sel),
  .done       (done)
);

// File: tb/sweep_logger_tb_top.sv
`timescale 1ns/1ps
module sweep_logger_tb_top;
  localparam int HI_W = 2;
  localparam int LO_W = 3;
  localparam int AW   = HI_W + LO_W;
  localparam int NADDR = 1 << AW;
  localparam int NMAP = 7;
  // {16-bit region start, 12-bit select pattern {grp_b, grp_a}}
  localparam logic [27:0] MAP_TBL [NMAP] = '{
    {16'h0000, 12'hFFE}, {16'h0004, 12'hFFD}, {16'h0008, 12'hFFF},
    {16'h000D, 12'h7FF}, {16'h0010, 12'hFFB}, {16'h0018, 12'hEFF},
    {16'h001F, 12'hF7F}
  };

  logic clk = 0;
  logic rst_n = 0, start = 0, rec_ready = 1;
  logic [15:0] rst_cycles = 16'd5;
  logic [7:0]  settle_cycles = 8'd6;
  logic [7:0]  sel_a;
  logic [3:0]  sel_b;
  logic [AW-1:0] tgt_addr, rec_addr;
  logic [11:0] rec_sel;
  logic tgt_rw, tgt_phi2, tgt_reset_n, rec_valid, done;

  always #2 clk = ~clk;

  sweep_logger #(.HI_W(HI_W), .LO_W(LO_W), .GA_W(8), .GB_W(4),
                 .RST_W(16), .SET_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_cycles(rst_cycles),
    .settle_cycles(settle_cycles), .sel_grp_a_n(sel_a), .sel_grp_b_n(sel_b),
    .tgt_addr(tgt_addr), .tgt_rw(tgt_rw), .tgt_phi2(tgt_phi2),
    .tgt_reset_n(tgt_reset_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_addr(rec_addr), .rec_sel(rec_sel), .done(done)
  );

  // Target model: decode with two cycles of latency.
  int  mode = 0;
  bit  stall_en = 1;
  logic [AW-1:0] a_d1 = '0, a_d2 = '0;
  always @(posedge clk) begin
    a_d1 <= tgt_addr;
    a_d2 <= a_d1;
  end

  function automatic logic [11:0] decode(input logic [AW-1:0] a, input int m);
    logic [11:0] s = 12'hFFF;
    if (m == 1) return 12'h5A3;
    for (int i = 0; i < NMAP; i++)
      if (16'(a) >= MAP_TBL[i][27:12]) s = MAP_TBL[i][11:0];
    return s;
  endfunction

  always_comb {sel_b, sel_a} = decode(a_d2, mode);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(posedge clk);
      #1 rec_ready = stall_en ? ((cyc % 7) >= 4) : 1'b1;
    end
  end

  // Monitor (sampled at negedge).
  int nrec = 0, rst_low = 0, addr_rst_bad = 0, order_bad = 0, naddr = 0;
  int nxt_exp = 0, stall_bad = 0, nstall = 0, done_bad = 0, rw_bad = 0;
  int hs_cyc = 0, done_cyc = 0;
  logic [AW-1:0] rec_a [16];
  logic [11:0]   rec_s [16];
  logic p_phi2 = 0, p_stall = 0, p_done = 0;
  logic [AW-1:0] p_a = '0, p_ta = '0;
  logic [11:0]   p_s = '0;

  always @(negedge clk) begin
    if (start) begin
      nrec = 0; rst_low = 0; addr_rst_bad = 0; order_bad = 0; naddr = 0;
      nxt_exp = 0; stall_bad = 0; nstall = 0; done_bad = 0; rw_bad = 0;
    end else if (rst_n) begin
      if (!tgt_reset_n) begin
        rst_low++;
        if (tgt_addr != '0) addr_rst_bad++;
      end
      if (!tgt_rw) rw_bad++;
      if (tgt_phi2 && !p_phi2) begin
        if (tgt_addr != AW'(nxt_exp)) order_bad++;
        nxt_exp++; naddr++;
      end
      if (p_stall) begin
        nstall++;
        if (!rec_valid || rec_addr != p_a || rec_sel != p_s || tgt_addr != p_ta) stall_bad++;
      end
      if (rec_valid && rec_ready) begin
        if (nrec < 16) begin rec_a[nrec] = rec_addr; rec_s[nrec] = rec_sel; end
        nrec++; hs_cyc = cyc;
      end
      if (done && (rec_valid || tgt_phi2)) done_bad++;
      if (done && !p_done) done_cyc = cyc;
    end
    p_phi2 = tgt_phi2; p_stall = rec_valid && !rec_ready;
    p_a = rec_addr; p_s = rec_sel; p_ta = tgt_addr; p_done = done;
  end

  int n_pass = 0, n_total = 0;
  bit wd = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic kick();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_done();
    while (!done && !wd) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    wd = 1;
    n_total++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tgt_reset_n == 1, "R1", "tgt_reset_n", tgt_reset_n, 1);
    chk(tgt_addr == 0,    "R1", "tgt_addr", tgt_addr, 0);
    chk(tgt_phi2 == 0,    "R1", "tgt_phi2", tgt_phi2, 0);
    chk(rec_valid == 0,   "R1", "rec_valid", rec_valid, 0);
    chk(done == 0,        "R1", "done", done, 0);

    // Sweep 1: mapped decode, stalling consumer.
    kick();
    wait_done();
    chk(rst_low == 6,      "R2", "reset low cycles", rst_low, 6);
    chk(addr_rst_bad == 0, "R2", "addr nonzero in reset", addr_rst_bad, 0);
    chk(naddr == NADDR,    "R3", "addresses presented", naddr, NADDR);
    chk(order_bad == 0,    "R3", "out of order addresses", order_bad, 0);
    chk(rw_bad == 0,       "R8", "write cycles", rw_bad, 0);
    chk(nrec == NMAP,      "R5", "record count", nrec, NMAP);
    for (int i = 0; i < NMAP; i++) begin
      chk(rec_a[i] == AW'(MAP_TBL[i][27:12]), "R5", "record addr", rec_a[i], MAP_TBL[i][27:12]);
      chk(rec_s[i] == MAP_TBL[i][11:0],       "R5", "record sel",  rec_s[i], MAP_TBL[i][11:0]);
    end
    chk(nstall > 0,        "R7", "stall cycles seen", nstall, 1);
    chk(stall_bad == 0,    "R7", "hold violations", stall_bad, 0);
    chk(done_cyc > hs_cyc, "R9", "done after last accept", done_cyc, hs_cyc + 1);
    repeat (10) @(negedge clk);
    chk(done == 1,         "R9", "done held", done, 1);
    chk(done_bad == 0,     "R9", "activity while done", done_bad, 0);

    // Sweep 2: constant decode, shortest reset, restart from done.
    mode = 1; stall_en = 0; rst_cycles = 16'd0;
    kick();
    chk(done == 0,         "R9", "done cleared by start", done, 0);
    wait_done();
    chk(rst_low == 1,      "R2", "reset low cycles min", rst_low, 1);
    chk(nrec == 1,         "R6", "single record", nrec, 1);
    chk(rec_a[0] == 0,     "R6", "first record addr", rec_a[0], 0);
    chk(rec_s[0] == 12'h5A3, "R6", "first record sel", rec_s[0], 12'h5A3);
    chk(naddr == NADDR,    "R4", "high phases per sweep", naddr, NADDR);
    chk(done == 1,         "R9", "done after sweep 2", done, 1);

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule